// File: doc/BRIEF.md
# Eight-Channel Shared-Period PWM Timer

This block is a PWM timer with eight outputs that all run from one 16-bit up-counter, so every output has the same period and only its duty differs. Software programs it through a small word-addressed register port. It selects the counter clock and a power-of-two prescale, sets the count range with a start value and a terminal value, and gives each channel a mode field and a compare value. An output mask and a polarity register shape the pins.

The counter advances on each prescaled tick. It runs from the start value up to the terminal value and then returns to the start value. A channel in edge-aligned mode drives high from the return point until the counter reaches its compare value. The level then passes through the channel's mask bit, which forces it low, and its polarity bit, which inverts it. A flop on the system clock drives the pin. While the counter runs, new terminal and compare values wait for the next return point, so a period already in progress never changes length or shape.

Top module: `shared_pwm_timer`

## Requirements
- R1: After reset, the output mask reads 0xFF, and the control, counter, start value, terminal value, compare values and polarity all read 0. All pins are low.
- R2: Registers are word-addressed. Control is at 0x00, with the prescale in bits [2:0] and the clock select in bits [4:3]. The live counter is at 0x04 and the terminal value at 0x08. Channel n has its mode field at 0x0C+8n (bits [5:0]) and its compare value at 0x10+8n. The start value is at 0x4C, the mask at 0x60 and the polarity at 0x70. Written fields read back, and unmapped addresses read 0.
- R3: Clock select 0 holds the counter. Select 1 advances it on every system clock, select 2 on each fixed-rate tick input and select 3 on each external tick input.
- R4: A prescale value p divides the selected tick stream by 2^p (1 to 128).
- R5: On each tick the counter increments. At or above the terminal value it reloads the start value instead, so the period is (terminal − start + 1) ticks. A write to the counter address loads the start value.
- R6: A channel whose mode field has bits 5 and 3 both set produces a high level while the counter is below its compare value. Any other mode gives a low level.
- R7: A compare value of 0 gives 0% duty. A compare value above the terminal value gives 100% duty.
- R8: A set mask bit forces that channel's level low ahead of the polarity stage.
- R9: A set polarity bit inverts that channel's final output.
- R10: While the counter runs, writes to the terminal and compare values take effect at the next reload. While the counter is stopped, they take effect at once.
- R11: Each pin is registered: a change in mask, polarity or counter appears on the pin one clock after the register update.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fix_tick | input | 1 | Fixed-rate counter clock enable |
| ext_tick | input | 1 | External counter clock enable |
| bus_we | input | 1 | Write strobe |
| bus_addr | input | 8 | Byte address, word-aligned |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| pwm_out | output | 8 | Channel outputs |

## Verification
The bench counts high cycles over a whole number of periods. The result does not depend on phase, so an off-by-one in the reload point or in the compare sense shows up as a duty error of one tick per period. Compare values of 0, 1, the terminal value, one above it and far above it test both ends of the duty range, and a design that compared with less-or-equal would leak one tick at 0%. The prescale values and the two tick inputs scale every count, so a wrong divider shows up as counts that are off by a whole factor. Shrinking the terminal value in mid-period catches a design that applies it at once, because that design reloads early. The mask and inverted channel together catch a design that applies polarity before the mask.

// File: rtl/pwmt_pkg.sv
package pwmt_pkg;

  typedef enum logic [1:0] {
    CS_OFF = 2'd0,
    CS_SYS = 2'd1,
    CS_FIX = 2'd2,
    CS_EXT = 2'd3
  } clk_sel_e;

  localparam logic [7:0] A_CTRL   = 8'h00;
  localparam logic [7:0] A_COUNT  = 8'h04;
  localparam logic [7:0] A_MOD    = 8'h08;
  localparam logic [7:0] A_CHCTL0 = 8'h0C;
  localparam logic [7:0] A_CHCV0  = 8'h10;
  localparam logic [7:0] A_INIT   = 8'h4C;
  localparam logic [7:0] A_MASK   = 8'h60;
  localparam logic [7:0] A_POL    = 8'h70;
  localparam int unsigned CH_STRIDE  = 8;
  localparam int unsigned MODE_W     = 6;
  localparam int unsigned MODE_SEL_B = 5;
  localparam int unsigned MODE_HI_B  = 3;

  // Edge-aligned high-true level: high while count is below the compare value
  function automatic logic pwm_level(input logic [31:0] cnt, input logic [31:0] cv,
                                     input logic en);
    return en && (cnt < cv);
  endfunction

  // Terminal count of the prescale divider for a given prescale code
  function automatic logic [31:0] div_limit(input logic [31:0] ps);
    return (32'd1 << ps) - 32'd1;
  endfunction

  function automatic logic mode_is_pwm(input logic [MODE_W-1:0] m);
    return m[MODE_SEL_B] && m[MODE_HI_B];
  endfunction

endpackage

// File: rtl/pwmt_regs.sv
module pwmt_regs
  import pwmt_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = 16,
  parameter int unsigned PSW = 3,
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_we,
  input  logic [AW-1:0]     bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  output logic [DW-1:0]     bus_rdata,
  input  logic [CW-1:0]     cnt_val,
  input  logic              reload,
  output clk_sel_e          clk_sel,
  output logic [PSW-1:0]    ps,
  output logic [CW-1:0]     init_val,
  output logic [CW-1:0]     mod_act,
  output logic              cnt_load,
  output logic [NCH-1:0]    ch_en,
  output logic [NCH*CW-1:0] cv_act_flat,
  output logic [NCH-1:0]    mask,
  output logic [NCH-1:0]    pol
);

  localparam int unsigned CS_LO = PSW;
  localparam int unsigned CS_HI = PSW + 1;

  logic stopped;
  logic hit_ctrl, hit_count, hit_mod, hit_init, hit_mask, hit_pol;
  logic [CW-1:0] mod_shd;
  logic [NCH-1:0] hit_ctl, hit_cv;
  logic [MODE_W-1:0] ch_mode [NCH];
  logic [CW-1:0] cv_shd [NCH];
  logic [CW-1:0] cv_act [NCH];

  assign stopped   = (clk_sel == CS_OFF);
  assign hit_ctrl  = (bus_addr == AW'(A_CTRL));
  assign hit_count = (bus_addr == AW'(A_COUNT));
  assign hit_mod   = (bus_addr == AW'(A_MOD));
  assign hit_init  = (bus_addr == AW'(A_INIT));
  assign hit_mask  = (bus_addr == AW'(A_MASK));
  assign hit_pol   = (bus_addr == AW'(A_POL));
  assign cnt_load  = bus_we && hit_count;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_sel  <= CS_OFF;
      ps       <= '0;
      init_val <= '0;
      mask     <= '1;
      pol      <= '0;
    end else if (bus_we) begin
      if (hit_ctrl) begin
        ps      <= bus_wdata[PSW-1:0];
        clk_sel <= clk_sel_e'(bus_wdata[CS_HI:CS_LO]);
      end
      if (hit_init) init_val <= bus_wdata[CW-1:0];
      if (hit_mask) mask     <= bus_wdata[NCH-1:0];
      if (hit_pol)  pol      <= bus_wdata[NCH-1:0];
    end
  end

  // Terminal value: shadow written by software, active copy used by the counter
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mod_shd <= '0;
      mod_act <= '0;
    end else begin
      if (reload) mod_act <= mod_shd;
      if (bus_we && hit_mod) begin
        mod_shd <= bus_wdata[CW-1:0];
        if (stopped) mod_act <= bus_wdata[CW-1:0];
      end
    end
  end

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign hit_ctl[i] = (bus_addr == AW'(32'(A_CHCTL0) + i * CH_STRIDE));
    assign hit_cv[i]  = (bus_addr == AW'(32'(A_CHCV0) + i * CH_STRIDE));
    assign ch_en[i]   = mode_is_pwm(ch_mode[i]);
    assign cv_act_flat[i*CW +: CW] = cv_act[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ch_mode[i] <= '0;
        cv_shd[i]  <= '0;
        cv_act[i]  <= '0;
      end else begin
        if (reload) cv_act[i] <= cv_shd[i];
        if (bus_we && hit_ctl[i]) ch_mode[i] <= bus_wdata[MODE_W-1:0];
        if (bus_we && hit_cv[i]) begin
          cv_shd[i] <= bus_wdata[CW-1:0];
          if (stopped) cv_act[i] <= bus_wdata[CW-1:0];
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (hit_ctrl)  bus_rdata = DW'({clk_sel, ps});
    if (hit_count) bus_rdata = DW'(cnt_val);
    if (hit_mod)   bus_rdata = DW'(mod_shd);
    if (hit_init)  bus_rdata = DW'(init_val);
    if (hit_mask)  bus_rdata = DW'(mask);
    if (hit_pol)   bus_rdata = DW'(pol);
    for (int i = 0; i < NCH; i++) begin
      if (hit_ctl[i]) bus_rdata = DW'(ch_mode[i]);
      if (hit_cv[i])  bus_rdata = DW'(cv_shd[i]);
    end
  end

endmodule

// File: rtl/pwmt_prescale.sv
module pwmt_prescale
  import pwmt_pkg::*;
#(
  parameter int unsigned PSW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  clk_sel_e       clk_sel,
  input  logic [PSW-1:0] ps,
  input  logic           fix_tick,
  input  logic           ext_tick,
  output logic           cnt_tick
);

  localparam int unsigned DVW = (1 << PSW) - 1;

  logic           src;
  logic           at_lim;
  logic [DVW-1:0] lim;
  logic [DVW-1:0] div_q;

  always_comb begin
    case (clk_sel)
      CS_SYS:  src = 1'b1;
      CS_FIX:  src = fix_tick;
      CS_EXT:  src = ext_tick;
      default: src = 1'b0;
    endcase
  end

  assign lim      = DVW'(div_limit(32'(ps)));
  assign at_lim   = (div_q >= lim);
  assign cnt_tick = src && at_lim;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                div_q <= '0;
    else if (clk_sel == CS_OFF) div_q <= '0;
    else if (src)              div_q <= at_lim ? '0 : div_q + 1'b1;
  end

endmodule

// File: rtl/pwmt_counter.sv
module pwmt_counter #(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cnt_tick,
  input  logic          cnt_load,
  input  logic [CW-1:0] init_val,
  input  logic [CW-1:0] mod_val,
  output logic [CW-1:0] cnt,
  output logic          reload
);

  logic at_top;

  assign at_top = (cnt >= mod_val);
  assign reload = cnt_tick && !cnt_load && at_top;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt <= '0;
    else if (cnt_load) cnt <= init_val;
    else if (cnt_tick) cnt <= at_top ? init_val : cnt + 1'b1;
  end

endmodule

// File: rtl/pwmt_outstage.sv
module pwmt_outstage
  import pwmt_pkg::*;
#(
  parameter int unsigned CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] cnt,
  input  logic [CW-1:0] cv,
  input  logic          en,
  input  logic          mask_b,
  input  logic          pol_b,
  output logic          pin
);

  logic raw;
  logic gated;

  assign raw   = pwm_level(32'(cnt), 32'(cv), en);
  assign gated = raw && !mask_b;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin <= 1'b0;
    else        pin <= gated ^ pol_b;
  end

endmodule

// File: rtl/shared_pwm_timer.sv
module shared_pwm_timer
  import pwmt_pkg::*;
#(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = 16,
  parameter int unsigned PSW = 3,
  parameter int unsigned AW  = 8,
  parameter int unsigned DW  = 32
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           fix_tick,
  input  logic           ext_tick,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [DW-1:0]  bus_wdata,
  output logic [DW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_out
);

  clk_sel_e          clk_sel;
  logic [PSW-1:0]    ps;
  logic [CW-1:0]     init_val;
  logic [CW-1:0]     mod_act;
  logic [CW-1:0]     cnt_q;
  logic              cnt_tick;
  logic              cnt_load;
  logic              reload;
  logic [NCH-1:0]    ch_en;
  logic [NCH*CW-1:0] cv_flat;
  logic [NCH-1:0]    mask;
  logic [NCH-1:0]    pol;

  pwmt_regs #(.NCH(NCH), .CW(CW), .PSW(PSW), .AW(AW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cnt_val(cnt_q),
    .reload(reload), .clk_sel(clk_sel), .ps(ps), .init_val(init_val),
    .mod_act(mod_act), .cnt_load(cnt_load), .ch_en(ch_en),
    .cv_act_flat(cv_flat), .mask(mask), .pol(pol)
  );

  pwmt_prescale #(.PSW(PSW)) u_pre (
    .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .ps(ps),
    .fix_tick(fix_tick), .ext_tick(ext_tick), .cnt_tick(cnt_tick)
  );

  pwmt_counter #(.CW(CW)) u_cnt (
    .clk(clk), .rst_n(rst_n), .cnt_tick(cnt_tick), .cnt_load(cnt_load),
    .init_val(init_val), .mod_val(mod_act), .cnt(cnt_q), .reload(reload)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_out
    pwmt_outstage #(.CW(CW)) u_os (
      .clk(clk), .rst_n(rst_n), .cnt(cnt_q), .cv(cv_flat[i*CW +: CW]),
      .en(ch_en[i]), .mask_b(mask[i]), .pol_b(pol[i]), .pin(pwm_out[i])
    );
  end

endmodule

// File: rtl/shared_pwm_timer_chk.sv
module shared_pwm_timer_chk #(
  parameter int unsigned NCH = 8,
  parameter int unsigned CW  = 16
) (
  input logic           clk,
  input logic           rst_n,
  input logic [1:0]     clk_sel,
  input logic           cnt_tick,
  input logic           cnt_load,
  input logic           reload,
  input logic [CW-1:0]  cnt_q,
  input logic [CW-1:0]  init_val,
  input logic [CW-1:0]  mod_act,
  input logic [NCH-1:0] mask,
  input logic [NCH-1:0] pol,
  input logic [NCH-1:0] pwm_out
);

  assert_tick_off_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd0) |-> !cnt_tick);

  assert_stop_holds_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel == 2'd0 && !cnt_load) |=> $stable(cnt_q));

  assert_reload_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
    reload |=> (cnt_q == $past(init_val)));

  assert_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_tick && !cnt_load && !reload) |=> (cnt_q == $past(cnt_q) + CW'(1)));

  assert_mask_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((pwm_out & $past(mask) & ~$past(pol)) == '0));

  assert_mod_buffer_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_sel != 2'd0 && !reload) |=> $stable(mod_act));

endmodule

bind shared_pwm_timer shared_pwm_timer_chk #(.NCH(NCH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clk_sel(clk_sel), .cnt_tick(cnt_tick),
  .cnt_load(cnt_load), .reload(reload), .cnt_q(cnt_q), .init_val(init_val),
  .mod_act(mod_act), .mask(mask), .pol(pol), .pwm_out(pwm_out)
);

// File: tb/test_shared_pwm_timer.sv
module test_shared_pwm_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fix_tick = 1'b0;
  logic        ext_tick = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  pwm_out;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  int fdiv = 0;

  typedef struct {
    int    ch;
    int    exp;
    string req;
  } item_t;
  item_t exp_q[$];

  int cfg_cv[8];
  bit cfg_en[8];
  int cfg_mask;
  int cfg_pol;

  shared_pwm_timer i_shared_pwm_timer (
    .clk(clk), .rst_n(rst_n), .fix_tick(fix_tick), .ext_tick(ext_tick),
    .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pwm_out(pwm_out)
  );

  always #10 clk = ~clk;

  // fixed-rate tick every 3rd cycle, external tick every 2nd
  always @(negedge clk) begin
    fdiv = (fdiv == 2) ? 0 : fdiv + 1;
    fix_tick = (fdiv == 0);
    ext_tick = ~ext_tick;
  end

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_addr = 8'(a); bus_wdata = 32'(d); bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, output int v);
    @(negedge clk);
    bus_addr = 8'(a);
    #1 v = int'(bus_rdata);
  endtask

  function automatic int exp_hi(int cv, int init, int md, int d, int per, bit en, bit m, bit p);
    int hp, win, raw;
    hp = en ? (((cv > md + 1) ? md + 1 : cv) - init) : 0;
    if (hp < 0) hp = 0;
    win = (md - init + 1) * d * per;
    raw = m ? 0 : hp * d * per;
    return p ? win - raw : raw;
  endfunction

  // program everything with the counter stopped, then start it
  task automatic apply_cfg(input int init, input int md, input int sel, input int ps);
    wr(32'h00, 0);
    wr(32'h4C, init);
    wr(32'h08, md);
    for (int c = 0; c < 8; c++) begin
      wr(32'h0C + 8 * c, cfg_en[c] ? 32'h28 : 32'h00);
      wr(32'h10 + 8 * c, cfg_cv[c]);
    end
    wr(32'h60, cfg_mask);
    wr(32'h70, cfg_pol);
    wr(32'h04, 0);
    wr(32'h00, (sel << 3) | ps);
  endtask

  // driver: push expected per-channel high counts
  task automatic drive_expect(input int init, input int md, input int d, input int per,
                              input string req);
    for (int c = 0; c < 8; c++) begin
      item_t it;
      it.ch = c;
      it.exp = exp_hi(cfg_cv[c], init, md, d, per, cfg_en[c], cfg_mask[c], cfg_pol[c]);
      it.req = req;
      exp_q.push_back(it);
    end
  endtask

  // monitor: count pin highs over whole periods, pop and compare
  task automatic monitor_window(input int init, input int md, input int d, input int per);
    int hi[8];
    int plen;
    plen = (md - init + 1) * d;
    for (int c = 0; c < 8; c++) hi[c] = 0;
    repeat (3 * plen + 4) @(negedge clk);
    repeat (plen * per) begin
      @(negedge clk);
      for (int c = 0; c < 8; c++) hi[c] += int'(pwm_out[c]);
    end
    while (exp_q.size() > 0) begin
      item_t it;
      it = exp_q.pop_front();
      check_eq(it.req, $sformatf("ch%0d high cycles", it.ch), hi[it.ch], it.exp);
    end
  endtask

  task automatic run_case(input int init, input int md, input int sel, input int ps,
                          input int d, input string req);
    apply_cfg(init, md, sel, ps);
    drive_expect(init, md, d, 2, req);
    monitor_window(init, md, d, 2);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int v, v2;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    check_eq("R1", "pins", int'(pwm_out), 0);
    rd(32'h60, v); check_eq("R1", "mask", v, 255);
    rd(32'h00, v); check_eq("R1", "ctrl", v, 0);
    rd(32'h04, v); check_eq("R1", "count", v, 0);
    rd(32'h08, v); check_eq("R1", "mod", v, 0);
    rd(32'h4C, v); check_eq("R1", "init", v, 0);
    rd(32'h70, v); check_eq("R1", "pol", v, 0);
    rd(32'h10, v); check_eq("R1", "cv0", v, 0);

    // R2 readback and decode
    wr(32'h00, 32'h0000_0015); rd(32'h00, v); check_eq("R2", "ctrl fields", v, 32'h15);
    wr(32'h00, 0);
    wr(32'h10 + 8 * 3, 32'h1234); rd(32'h10 + 8 * 3, v); check_eq("R2", "cv3", v, 32'h1234);
    wr(32'h0C + 8 * 5, 32'h28); rd(32'h0C + 8 * 5, v); check_eq("R2", "ctl5", v, 32'h28);
    wr(32'h08, 32'h1_0042); rd(32'h08, v); check_eq("R2", "mod 16-bit", v, 32'h42);
    rd(32'h58, v); check_eq("R2", "unmapped", v, 0);

    // R3 stopped counter holds; R5 count write loads start value
    wr(32'h4C, 5); wr(32'h04, 0);
    rd(32'h04, v); repeat (20) @(negedge clk); rd(32'h04, v2);
    check_eq("R5", "count after load", v, 5);
    check_eq("R3", "stopped count stable", v2, v);

    // R6 R7: system clock, no prescale, mix of compare values
    cfg_cv = '{0, 5, 10, 19, 20, 200, 1, 10};
    cfg_en = '{1, 1, 1, 1, 1, 1, 1, 0};
    cfg_mask = 0; cfg_pol = 0;
    run_case(0, 19, 1, 0, 1, "R6/R7");

    // R4 prescale by 4
    run_case(0, 19, 1, 2, 4, "R4");
    // R3 fixed-rate tick (every 3rd cycle)
    run_case(0, 19, 2, 0, 3, "R3 fix");
    // R3 external tick (every 2nd) with prescale by 2
    run_case(0, 19, 3, 1, 4, "R3 ext");

    // R8 R9 mask and polarity
    cfg_mask = 32'b1000_0110; cfg_pol = 32'b0100_0100;
    run_case(0, 19, 1, 0, 1, "R8/R9");

    // R5 nonzero start value
    cfg_mask = 0; cfg_pol = 0;
    run_case(5, 19, 1, 0, 1, "R5");

    // R10 terminal value buffered while running
    wr(32'h00, 0); wr(32'h4C, 0); wr(32'h08, 199); wr(32'h04, 0);
    wr(32'h00, 32'h08);
    repeat (100) @(negedge clk);
    wr(32'h08, 49);
    rd(32'h08, v); check_eq("R10", "mod shadow readback", v, 49);
    repeat (3) @(negedge clk);
    rd(32'h04, v); check_eq("R10", "count past new mod before reload", int'(v > 49), 1);
    repeat (200) @(negedge clk);
    rd(32'h04, v); check_eq("R10", "count within new mod after reload", int'(v <= 49), 1);

    // R11 pin follows mask write one clock later
    wr(32'h00, 0); wr(32'h60, 32'hFF); wr(32'h04, 0);
    wr(32'h0C, 32'h28); wr(32'h10, 5);
    wr(32'h60, 32'hFE);
    #1 check_eq("R11", "pin0 one clock after mask write", int'(pwm_out[0]), 0);
    @(negedge clk);
    #1 check_eq("R11", "pin0 two clocks after mask write", int'(pwm_out[0]), 1);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule